// File: doc/BRIEF.md
# Two-Level Mirrored Interrupt Status

This block collects interrupt events into two status words. Audio event pulses set bits in a second-level word. Other system event pulses set bits in a top-level word. The top-level word also carries one audio summary bit, which is high while any second-level bit is pending. An interrupt handler reads the top word first to find the cause. When the audio bit is set, it then reads the second word.

Each word can be read at two addresses, and both return the same data. The mirror address leaves the status as it is. The read-to-clear address clears exactly the bits it returned. Clearing the top word clears only its system bits. The audio summary falls only when the second-level word is cleared. An event that arrives in the same cycle as a clearing read is kept, so no event is lost. The interrupt request output is high while any top-level bit is pending.

Top module: `irq_status_2lvl`

## Requirements
- R1: After reset all status bits are clear, `irq_o` is low and `rd_data_o` is zero.
- R2: A one-cycle pulse on `sys_evt_i[k]` sets top bit k. A pulse on `audio_evt_i[j]` sets second-level bit j. Each bit stays set until a clearing read removes it.
- R3: Top word layout: bits [N_SYS-1:0] hold the system bits. Bit N_SYS is the OR of all second-level bits. All higher bits read zero. Second-level word layout: bits [N_AUDIO-1:0] hold the audio bits, and all higher bits read zero.
- R4: `rd_data_o` shows the addressed word in the cycle after `rd_en_i` is sampled high. The word is the value the bits had before that edge. `rd_data_o` is zero after a cycle with no strobe, and zero after a read of any address other than 0x00, 0x02, 0x10 or 0x12. Such reads change no status.
- R5: Reads at 0x00 (top mirror) and 0x10 (second-level mirror) never change any status bit.
- R6: A read at 0x02 returns the same word as 0x00. It clears the system bits it returned. It leaves the audio summary and the second-level word untouched.
- R7: A read at 0x12 returns the same word as 0x10 and clears the second-level bits it returned. The top audio bit then falls, unless a new audio event arrived.
- R8: An event pulse in the same cycle as a clearing read of its word remains set after that read.
- R9: `irq_o` is high in the cycle after any top-level bit, including the audio summary, becomes pending. It is low once all top-level bits are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sys_evt_i | input | N_SYS | Single-cycle system event pulses (top level) |
| audio_evt_i | input | N_AUDIO | Single-cycle audio event pulses (second level) |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 5 | Byte offset of the read |
| rd_data_o | output | 16 | Read data, one cycle after the strobe |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A pending bit that is wrongly lost or kept appears at the ports on the next mirror read, one cycle after its strobe. The interrupt request shows the same fault in the cycle after the faulty clear. A clear mask that covers more bits than were returned shows up only when an event collides with a clearing read. For that reason the collision case is driven directly for both levels. An audio summary that is cached, rather than derived from the second level, leaves the top bit high after a second-level clear. That fault is visible on the next top-level read.

// File: rtl/irqst_pkg.sv
package irqst_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 16;

  localparam logic [ADDR_W-1:0] OFS_TOP_MIR = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_TOP_CLR = 5'h02;
  localparam logic [ADDR_W-1:0] OFS_AUD_MIR = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_AUD_CLR = 5'h12;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_TOP_MIR,
    RD_TOP_CLR,
    RD_AUD_MIR,
    RD_AUD_CLR
  } rd_kind_e;
endpackage

// File: rtl/irqst_pend_bank.sv
module irqst_pend_bank #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] clr_mask_i,
  output logic [W-1:0] pend_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    // set wins over clear so a colliding event survives
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_o[i] <= 1'b0;
      else         pend_o[i] <= evt_i[i] | (pend_o[i] & ~clr_mask_i[i]);
    end
  end
endmodule

// File: rtl/irqst_rd_decode.sv
module irqst_rd_decode
  import irqst_pkg::*;
(
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] top_word_i,
  input  logic [DATA_W-1:0] aud_word_i,
  output logic [DATA_W-1:0] data_o,
  output logic              clr_top_o,
  output logic              clr_aud_o
);
  rd_kind_e kind;

  always_comb begin
    kind = RD_NONE;
    if (rd_en_i) begin
      unique case (rd_addr_i)
        OFS_TOP_MIR: kind = RD_TOP_MIR;
        OFS_TOP_CLR: kind = RD_TOP_CLR;
        OFS_AUD_MIR: kind = RD_AUD_MIR;
        OFS_AUD_CLR: kind = RD_AUD_CLR;
        default:     kind = RD_NONE;
      endcase
    end
  end

  always_comb begin
    data_o    = '0;
    clr_top_o = 1'b0;
    clr_aud_o = 1'b0;
    unique case (kind)
      RD_TOP_MIR: data_o = top_word_i;
      RD_TOP_CLR: begin data_o = top_word_i; clr_top_o = 1'b1; end
      RD_AUD_MIR: data_o = aud_word_i;
      RD_AUD_CLR: begin data_o = aud_word_i; clr_aud_o = 1'b1; end
      default:    data_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_status_2lvl.sv
module irq_status_2lvl
  import irqst_pkg::*;
#(
  parameter int unsigned N_SYS   = 3,
  parameter int unsigned N_AUDIO = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_SYS-1:0]     sys_evt_i,
  input  logic [N_AUDIO-1:0]   audio_evt_i,
  input  logic                 rd_en_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  output logic [DATA_W-1:0]    rd_data_o,
  output logic                 irq_o
);
  localparam int unsigned AUD_BIT = N_SYS;

  logic [N_SYS-1:0]   sys_pend;
  logic [N_AUDIO-1:0] aud_pend;
  logic [N_SYS-1:0]   sys_clr;
  logic [N_AUDIO-1:0] aud_clr;
  logic [DATA_W-1:0]  top_word;
  logic [DATA_W-1:0]  aud_word;
  logic [DATA_W-1:0]  rd_word;
  logic               clr_top;
  logic               clr_aud;
  logic               aud_sum;

  assign aud_sum = |aud_pend;

  always_comb begin
    top_word          = '0;
    top_word[N_SYS-1:0] = sys_pend;
    top_word[AUD_BIT] = aud_sum;
    aud_word          = '0;
    aud_word[N_AUDIO-1:0] = aud_pend;
  end

  // clear only what this read returns
  assign sys_clr = clr_top ? sys_pend : '0;
  assign aud_clr = clr_aud ? aud_pend : '0;

  irqst_pend_bank #(.W(N_SYS)) u_sys_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (sys_evt_i),
    .clr_mask_i (sys_clr),
    .pend_o     (sys_pend)
  );

  irqst_pend_bank #(.W(N_AUDIO)) u_aud_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (audio_evt_i),
    .clr_mask_i (aud_clr),
    .pend_o     (aud_pend)
  );

  irqst_rd_decode u_dec (
    .rd_en_i    (rd_en_i),
    .rd_addr_i  (rd_addr_i),
    .top_word_i (top_word),
    .aud_word_i (aud_word),
    .data_o     (rd_word),
    .clr_top_o  (clr_top),
    .clr_aud_o  (clr_aud)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else         rd_data_o <= rd_word;
  end

  assign irq_o = |top_word;
endmodule

// File: rtl/irq_status_2lvl_chk.sv
module irq_status_2lvl_chk
  import irqst_pkg::*;
#(
  parameter int unsigned N_SYS   = 3,
  parameter int unsigned N_AUDIO = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_SYS-1:0]   sys_evt_i,
  input logic [N_AUDIO-1:0] audio_evt_i,
  input logic               rd_en_i,
  input logic [ADDR_W-1:0]  rd_addr_i,
  input logic [DATA_W-1:0]  rd_data_o,
  input logic               irq_o,
  input logic [N_SYS-1:0]   sys_pend,
  input logic [N_AUDIO-1:0] aud_pend
);
  assert_mirror_keeps_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && (rd_addr_i == OFS_TOP_MIR || rd_addr_i == OFS_AUD_MIR) |=>
      ((sys_pend & $past(sys_pend)) == $past(sys_pend)) &&
      ((aud_pend & $past(aud_pend)) == $past(aud_pend)));

  assert_top_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && rd_addr_i == OFS_TOP_CLR |=>
      (sys_pend == $past(sys_evt_i)) &&
      ((aud_pend & $past(aud_pend)) == $past(aud_pend)));

  assert_aud_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && rd_addr_i == OFS_AUD_CLR |=> aud_pend == $past(audio_evt_i));

  assert_evt_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((aud_pend & $past(audio_evt_i)) == $past(audio_evt_i)) &&
             ((sys_pend & $past(sys_evt_i)) == $past(sys_evt_i)));

  assert_idle_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> rd_data_o == '0);

  assert_aud_mirror_data_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && rd_addr_i == OFS_AUD_MIR |=> rd_data_o[N_AUDIO-1:0] == $past(aud_pend));

  assert_irq_on_event_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|audio_evt_i) || (|sys_evt_i) |=> irq_o);
endmodule

bind irq_status_2lvl irq_status_2lvl_chk #(.N_SYS(N_SYS), .N_AUDIO(N_AUDIO)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sys_evt_i   (sys_evt_i),
  .audio_evt_i (audio_evt_i),
  .rd_en_i     (rd_en_i),
  .rd_addr_i   (rd_addr_i),
  .rd_data_o   (rd_data_o),
  .irq_o       (irq_o),
  .sys_pend    (sys_pend),
  .aud_pend    (aud_pend)
);

// File: tb/irq_status_2lvl_bench.sv
`timescale 1ns/1ps
module irq_status_2lvl_bench;
  localparam int NS = 3;
  localparam int NA = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] sys_evt = '0;
  logic [NA-1:0] aud_evt = '0;
  logic          rd_en = 1'b0;
  logic [4:0]    rd_addr = '0;
  logic [15:0]   rd_data;
  logic          irq;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  irq_status_2lvl #(.N_SYS(NS), .N_AUDIO(NA)) u_irq_status_2lvl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .sys_evt_i   (sys_evt),
    .audio_evt_i (aud_evt),
    .rd_en_i     (rd_en),
    .rd_addr_i   (rd_addr),
    .rd_data_o   (rd_data),
    .irq_o       (irq)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [NS-1:0] s, input logic [NA-1:0] a);
    @(negedge clk);
    sys_evt = s; aud_evt = a;
    @(negedge clk);
    sys_evt = '0; aud_evt = '0;
  endtask

  task automatic rd(input logic [4:0] addr, input logic [NS-1:0] s,
                    input logic [NA-1:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = addr; sys_evt = s; aud_evt = a;
    @(negedge clk);
    rd_en = 1'b0; sys_evt = '0; aud_evt = '0;
    d = rd_data;
  endtask

  function automatic logic [15:0] top_exp(input logic [NS-1:0] s, input logic [NA-1:0] a);
    logic [15:0] v;
    v = '0;
    v[NS-1:0] = s;
    v[NS] = (a != '0);
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    chk(rd_data, 16'h0, "R1 rd_data after reset");
    chk({15'h0, irq}, 16'h0, "R1 irq after reset");
    rst_n = 1'b1;

    // sweep every system and audio pattern
    for (int s = 0; s < (1 << NS); s++) begin
      for (int a = 0; a < (1 << NA); a++) begin
        logic [15:0] e;
        e = top_exp(NS'(s), NA'(a));
        pulse(NS'(s), NA'(a));
        chk({15'h0, irq}, {15'h0, e != 16'h0}, "R9 irq pending");
        rd(5'h00, '0, '0, d); chk(d, e, "R2/R3 top mirror");
        rd(5'h02, '0, '0, d); chk(d, e, "R6 top clear returns same");
        rd(5'h00, '0, '0, d); chk(d, top_exp('0, NA'(a)), "R6 sys cleared audio kept");
        rd(5'h10, '0, '0, d); chk(d, 16'(a), "R3 second mirror");
        rd(5'h12, '0, '0, d); chk(d, 16'(a), "R7 second clear returns same");
        rd(5'h10, '0, '0, d); chk(d, 16'h0, "R7 second cleared");
        rd(5'h00, '0, '0, d); chk(d, 16'h0, "R7 summary fell");
        chk({15'h0, irq}, 16'h0, "R9 irq low");
      end
    end

    // collision with clearing reads
    pulse(3'b111, 4'b0000);
    rd(5'h02, 3'b101, '0, d); chk(d, 16'h0007, "R8 top clear value");
    rd(5'h00, '0, '0, d);     chk(d, 16'h0005, "R8 top event kept");
    pulse('0, 4'b1011);
    rd(5'h12, '0, 4'b0010, d); chk(d, 16'h000b, "R8 second clear value");
    rd(5'h10, '0, '0, d);      chk(d, 16'h0002, "R8 second event kept");
    rd(5'h00, 3'b010, '0, d);  chk(d, 16'h000d, "R4 mirror shows pre-edge value");
    rd(5'h00, '0, '0, d);      chk(d, 16'h000f, "R2 late event visible");
    rd(5'h02, '0, '0, d);
    rd(5'h12, '0, '0, d);
    rd(5'h00, '0, '0, d);      chk(d, 16'h0, "R6/R7 all clear");

    // unmapped addresses and idle cycle
    pulse(3'b010, 4'b0100);
    for (int ad = 0; ad < 32; ad++) begin
      if (ad != 0 && ad != 2 && ad != 16 && ad != 18) begin
        rd(5'(ad), '0, '0, d);
        chk(d, 16'h0, "R4 unmapped reads zero");
      end
    end
    @(negedge clk);
    chk(rd_data, 16'h0, "R4 idle zero");
    rd(5'h00, '0, '0, d);  chk(d, 16'h000a, "R4/R5 status unchanged");
    rd(5'h10, '0, '0, d);  chk(d, 16'h0004, "R5 second unchanged");
    rd(5'h10, '0, '0, d);  chk(d, 16'h0004, "R5 mirror repeat");

    // reset with pending bits
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk({15'h0, irq}, 16'h0, "R1 irq cleared by reset");
    rst_n = 1'b1;
    rd(5'h00, '0, '0, d);  chk(d, 16'h0, "R1 top clear after reset");
    rd(5'h10, '0, '0, d);  chk(d, 16'h0, "R1 second clear after reset");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule